// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with three small registers on a simple word-write, byte-read bus. Every write is a 16-bit word, and its upper byte must equal the key that belongs to the target register, or the write has no effect. The lower byte carries the payload. A clock-select field picks one of eight prescaler ratios. Each prescaled tick advances an 8-bit up-counter. Firmware reloads the counter periodically so that it never passes 255.

When the counter passes 255, it wraps to zero and sets a sticky overflow flag. The block asserts a fixed-length system reset request only when the timer is in watchdog mode and reset generation is enabled. In interval mode an overflow sets the flag and nothing else. The flag survives the reset pulse. It can be cleared only by the dedicated clear word, and only after a bus read strobe has sampled the flag while it was set.

Top module: `key_wdt`

## Requirements
- R1: A write to offset 0 with upper byte 0xA5 loads the control register from the low byte: bit 6 selects watchdog mode (1) or interval mode (0), bit 5 runs the timer, and bits 2:0 select the clock. Reading offset 0 returns these bits in the same positions, with all other bits zero.
- R2: A write to offset 2 with upper byte 0x5A loads the low byte into the counter. Reading offset 2 returns the live counter value.
- R3: A write to offset 4 with upper byte 0x5A sets reset-enable from bit 6 of the low byte. Reading offset 4 returns the overflow flag in bit 7 and reset-enable in bit 6. While reset-enable is 0, no reset request is ever produced.
- R4: A write whose upper byte does not match the key of its register changes no state. The exception is the clear word described in R9.
- R5: While the timer runs, the counter advances by one every D input clocks. D is 1, 64, 128, 256, 512, 1024, 4096 or 16384 for clock-select values 0 to 7. Stopping the timer freezes the counter and restarts the prescaler from zero.
- R6: An advance from 255 wraps the counter to 0 and sets the overflow flag. The flag stays set through any reset pulse until it is validly cleared.
- R7: An overflow in watchdog mode with reset-enable set raises `sys_rst_req` on the next clock. The request stays high for exactly PULSE_LEN clocks (default 128). A further overflow during the pulse does not extend it.
- R8: An overflow in interval mode never raises `sys_rst_req`.
- R9: Writing exactly 0xA500 to offset 4 clears the flag, but only if a read strobe at offset 4 has seen the flag set since the last clear. Without such a read, the clear word is ignored. The clear word leaves reset-enable unchanged.
- R10: After reset, every register reads zero and `sys_rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Write word: key in the upper byte, payload in the lower byte |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
A wrong prescaler phase shows up as a counter readback that is off by one tick. The error appears within one divider period of the timer starting and grows from there. A wrong flag or arm state shows up on the next read of offset 4, or as a clear word that takes effect when it should not, or fails when it should. Errors in the pulse logic appear on `sys_rst_req` one clock after the overflow, or at the first clock where the pulse should have ended. The bench compares readback and the reset request on every clock, so each of these errors is caught in the cycle it first reaches a port.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_RST  = 3'd4;

   localparam logic [7:0]  KEY_CTRL      = 8'hA5;
   localparam logic [7:0]  KEY_CNT       = 8'h5A;
   localparam logic [7:0]  KEY_RST       = 8'h5A;
   localparam logic [15:0] FLAG_CLR_WORD = 16'hA500;

   localparam int unsigned MODE_BIT  = 6;
   localparam int unsigned RUN_BIT   = 5;
   localparam int unsigned RSTEN_BIT = 6;

   typedef struct packed {
      logic       wdt_mode;
      logic       run;
      logic [2:0] sel;
   } ctrl_t;

   function automatic logic [15:0] sel_to_div(input logic [2:0] s);
      logic [15:0] d;
      unique case (s)
         3'd0:    d = 16'd1;
         3'd1:    d = 16'd64;
         3'd2:    d = 16'd128;
         3'd3:    d = 16'd256;
         3'd4:    d = 16'd512;
         3'd5:    d = 16'd1024;
         3'd6:    d = 16'd4096;
         default: d = 16'd16384;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
   import kwdt_pkg::*;
#(
   parameter int unsigned PRE_W = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       tick
);

   initial begin
      assert (PRE_W >= 14 && PRE_W <= 16)
         else $error("kwdt_prescale: PRE_W must be 14..16");
   end

   logic [PRE_W-1:0] pc;
   logic [15:0]      lim;

   always_comb begin
      lim  = sel_to_div(sel) - 16'd1;
      tick = run && (32'(pc) >= 32'(lim));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else if (!run || tick)
         pc <= '0;
      else
         pc <= pc + 1'b1;
   end

   // R5: prescaler restarts whenever stopped
   a_r5_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pc == '0));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] TOP = '1;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 8)
         else $error("kwdt_counter: CNT_W must be 2..8");
   end

   assign ovf = tick && !load && (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (tick)
         cnt <= cnt + 1'b1;
   end

   // R5: no tick and no load keeps the count
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));

   // R6: passing the top wraps to zero
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == TOP) |=> (cnt == '0));

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
   parameter int unsigned PULSE_LEN = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req
);

   localparam int unsigned PW = $clog2(PULSE_LEN + 1);

   initial begin
      assert (PULSE_LEN >= 1)
         else $error("kwdt_pulse: PULSE_LEN must be at least 1");
   end

   generate
      if (PULSE_LEN == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               req <= 1'b0;
            else
               req <= fire && !req;
         end
      end else begin : g_counted
         logic [PW-1:0] left;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left <= '0;
            else if (left != '0)
               left <= left - 1'b1;
            else if (fire)
               left <= PW'(PULSE_LEN);
         end

         assign req = (left != '0);
      end
   endgenerate

   // R7: an idle fire starts the request on the next clock
   a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !req) |=> req);

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [15:0]       wdata,
   input  logic              rd,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              ovf,
   output ctrl_t             ctrl,
   output logic              rst_en,
   output logic              flag,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic [7:0]        rdata
);

   logic       armed;
   logic       wr_ctrl, wr_rst, clr_hit, clr_ok;
   logic [7:0] key;

   always_comb begin
      key      = wdata[15:8];
      wr_ctrl  = wr && (addr == OFS_CTRL) && (key == KEY_CTRL);
      load     = wr && (addr == OFS_CNT)  && (key == KEY_CNT);
      wr_rst   = wr && (addr == OFS_RST)  && (key == KEY_RST);
      clr_hit  = wr && (addr == OFS_RST)  && (wdata == FLAG_CLR_WORD);
      clr_ok   = clr_hit && armed;
      load_val = wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl.wdt_mode <= wdata[MODE_BIT];
         ctrl.run      <= wdata[RUN_BIT];
         ctrl.sel      <= wdata[2:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rst_en <= 1'b0;
      else if (wr_rst)
         rst_en <= wdata[RSTEN_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (clr_ok)
         armed <= 1'b0;
      else if (rd && (addr == OFS_RST) && flag)
         armed <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (ovf)
         flag <= 1'b1;
      else if (clr_ok)
         flag <= 1'b0;
   end

   always_comb begin
      unique case (addr)
         OFS_CTRL: rdata = {1'b0, ctrl.wdt_mode, ctrl.run, 2'b00, ctrl.sel};
         OFS_CNT:  rdata = 8'(cnt_val);
         OFS_RST:  rdata = {flag, rst_en, 6'b0};
         default:  rdata = 8'h00;
      endcase
   end

   // R4: a control write with the wrong key leaves control untouched
   a_r4_ctrl_key: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS_CTRL && wdata[15:8] != KEY_CTRL) |=> $stable(ctrl));

   // R9: without a qualifying read, the flag cannot drop
   a_r9_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !armed) |=> flag);

   // R6: an overflow always leaves the flag set
   a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> flag);

endmodule

// File: rtl/key_wdt.sv
module key_wdt
   import kwdt_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned PRE_W     = 14,
   parameter int unsigned PULSE_LEN = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  bus_addr,
   input  logic        bus_wr,
   input  logic [15:0] bus_wdata,
   input  logic        bus_rd,
   output logic [7:0]  bus_rdata,
   output logic        sys_rst_req
);

   ctrl_t            ctrl;
   logic             rst_en, flag, load, tick, ovf, fire;
   logic [CNT_W-1:0] load_val, cnt;

   kwdt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .rd       (bus_rd),
      .cnt_val  (cnt),
      .ovf      (ovf),
      .ctrl     (ctrl),
      .rst_en   (rst_en),
      .flag     (flag),
      .load     (load),
      .load_val (load_val),
      .rdata    (bus_rdata)
   );

   kwdt_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl.run),
      .sel   (ctrl.sel),
      .tick  (tick)
   );

   kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .tick     (tick),
      .cnt      (cnt),
      .ovf      (ovf)
   );

   assign fire = ovf && ctrl.wdt_mode && rst_en;

   kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .req   (sys_rst_req)
   );

   // R8: an overflow in interval mode never starts a request
   a_r8_interval_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ctrl.wdt_mode && !sys_rst_req) |=> !sys_rst_req);

   // R3: with reset disabled, no new request starts
   a_r3_rsten_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_en && !sys_rst_req) |=> !sys_rst_req);

endmodule

// File: tb/tb_key_wdt.sv
`timescale 1ns/100ps
module tb_key_wdt;

   localparam int PL = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic        sys_rst_req;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   key_wdt #(.PULSE_LEN(PL)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .sys_rst_req(sys_rst_req)
   );

   // behavioural reference model
   bit m_mode, m_run, m_rsten, m_flag, m_armed;
   int m_sel, m_cnt, m_pre, m_pulse;

   function automatic int divof(input int s);
      case (s)
         0: return 1;
         1: return 64;
         2: return 128;
         3: return 256;
         4: return 512;
         5: return 1024;
         6: return 4096;
         default: return 16384;
      endcase
   endfunction

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {1'b0, m_mode, m_run, 2'b00, 3'(m_sel)};
         3'd2: return 8'(m_cnt);
         3'd4: return {m_flag, m_rsten, 6'b0};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit tk, ld, ov, fr, okc;
      if (!rst_n) begin
         m_mode = 0; m_run = 0; m_rsten = 0; m_flag = 0; m_armed = 0;
         m_sel = 0; m_cnt = 0; m_pre = 0; m_pulse = 0;
      end else begin
         tk  = m_run && (m_pre >= divof(m_sel) - 1);
         ld  = bus_wr && bus_addr == 3'd2 && bus_wdata[15:8] == 8'h5A;
         ov  = tk && !ld && m_cnt == 255;
         fr  = ov && m_mode && m_rsten;
         okc = bus_wr && bus_addr == 3'd4 && bus_wdata == 16'hA500 && m_armed;
         if (!m_run || tk) m_pre = 0; else m_pre = m_pre + 1;
         if (ld) m_cnt = int'(bus_wdata[7:0]);
         else if (tk) m_cnt = (m_cnt + 1) % 256;
         if (okc) m_armed = 0;
         else if (bus_rd && bus_addr == 3'd4 && m_flag) m_armed = 1;
         if (ov) m_flag = 1; else if (okc) m_flag = 0;
         if (m_pulse > 0) m_pulse = m_pulse - 1;
         else if (fr) m_pulse = PL;
         if (bus_wr && bus_addr == 3'd0 && bus_wdata[15:8] == 8'hA5) begin
            m_mode = bus_wdata[6]; m_run = bus_wdata[5]; m_sel = int'(bus_wdata[2:0]);
         end
         if (bus_wr && bus_addr == 3'd4 && bus_wdata[15:8] == 8'h5A)
            m_rsten = bus_wdata[6];
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_vec++;
         if (bus_rdata !== m_read(bus_addr)) begin
            n_bad++;
            $display("FAIL %s readback @%0d: actual %02h expected %02h",
                     (bus_addr == 3'd0) ? "R1" : (bus_addr == 3'd2) ? "R5" : "R6",
                     bus_addr, bus_rdata, m_read(bus_addr));
         end
         n_vec++;
         if (sys_rst_req !== (m_pulse > 0)) begin
            n_bad++;
            $display("FAIL R7 sys_rst_req: actual %0b expected %0b",
                     sys_rst_req, (m_pulse > 0));
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr16(input logic [2:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd8(input logic [2:0] a);
      @(posedge clk); #1;
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output int v);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      v = int'(bus_rdata);
   endtask

   task automatic spin(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sys_rst_req) hi++;
      end
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int v, v2, hi;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10 reset state
      peek(3'd0, v); chk("R10 ctrl", v, 'h00);
      peek(3'd2, v); chk("R10 cnt", v, 'h00);
      peek(3'd4, v); chk("R10 rst", v, 'h00);
      chk("R10 req", int'(sys_rst_req), 0);

      // R4 wrong keys, R1/R2/R3 keyed writes
      wr16(3'd0, 16'h5A27); peek(3'd0, v); chk("R4 ctrl key", v, 'h00);
      wr16(3'd2, 16'hA510); peek(3'd2, v); chk("R4 cnt key", v, 'h00);
      wr16(3'd4, 16'h1240); peek(3'd4, v); chk("R4 rst key", v, 'h00);
      wr16(3'd2, 16'h5AF0); peek(3'd2, v); chk("R2 load", v, 'hF0);
      wr16(3'd4, 16'h5A40); peek(3'd4, v); chk("R3 rsten", v, 'h40);
      wr16(3'd0, 16'hA547); peek(3'd0, v); chk("R1 ctrl", v, 'h47);
      wr16(3'd0, 16'hA500); peek(3'd0, v); chk("R1 stop", v, 'h00);

      // R8 interval overflow at divide-by-1
      wr16(3'd0, 16'hA520);
      spin(25, hi); chk("R8 no req", hi, 0);
      peek(3'd4, v); chk("R6 flag set", v, 'hC0);

      // R5 stopped counter holds
      wr16(3'd0, 16'hA500);
      peek(3'd2, v); spin(12, hi); peek(3'd2, v2);
      chk("R5 hold", v2, v);

      // R9 clear needs a prior read strobe
      wr16(3'd4, 16'hA500); peek(3'd4, v); chk("R9 unarmed", v, 'hC0);
      rd8(3'd4);
      wr16(3'd4, 16'hA500); peek(3'd4, v); chk("R9 cleared", v, 'h40);

      // R5 divide by 64
      wr16(3'd2, 16'h5AFE);
      wr16(3'd0, 16'hA521);
      spin(50, hi); peek(3'd2, v); chk("R5 div64 early", v, 'hFE);
      spin(40, hi); peek(3'd2, v); chk("R5 div64 step", v, 'hFF);
      spin(80, hi); peek(3'd4, v); chk("R6 div64 ovf", v, 'hC0);
      wr16(3'd0, 16'hA527);
      peek(3'd2, v); spin(200, hi); peek(3'd2, v2);
      chk("R5 div16384 slow", v2, v);
      wr16(3'd0, 16'hA500);
      rd8(3'd4); wr16(3'd4, 16'hA500);

      // R7 watchdog reset pulse
      wr16(3'd2, 16'h5AFF);
      wr16(3'd0, 16'hA560);
      spin(200, hi); chk("R7 pulse length", hi, PL);
      peek(3'd4, v); chk("R6 flag across pulse", v, 'hC0);
      wr16(3'd0, 16'hA500);
      rd8(3'd4); wr16(3'd4, 16'hA500);

      // R3 reset disabled: watchdog overflow gives no request
      wr16(3'd4, 16'h5A00);
      wr16(3'd2, 16'h5AFF);
      wr16(3'd0, 16'hA560);
      spin(20, hi); chk("R3 no req", hi, 0);
      peek(3'd4, v); chk("R3 flag only", v, 'h80);
      wr16(3'd0, 16'hA500);

      spin(4, hi);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule